// File: doc/BRIEF.md
# Base-Relative Rotating Register File

This block is a 32-bit register file whose architectural register numbers are split into three ranges. Numbers 0 to 63 name a global bank and are always used as they are. Numbers 128 to 255 name a 128-entry local bank, but each local number is first moved by an offset. The offset comes from global register 1, and the move wraps around inside the local bank. Numbers 64 to 127 are unused.

Software sets the offset to open a register frame of any size for a procedure call. A callee that needs three registers moves the offset by three and no further, because the bank is not cut into windows of fixed size. The block has two combinational read ports and one write port that updates on the clock edge. All three ports take an 8-bit register number. The full content of the base register is also brought out on a port.

Top module: `rrf_rotating_regfile`

## Requirements
- R1: A register number from 0 to 63 reaches global entry number equal to the register number, whatever the base offset is.
- R2: A register number n from 128 to 255 reaches local entry (n − 128 + b) mod 128, where b is bits [6:0] of global register 1. With b = 10, number 128 reaches local entry 10.
- R3: Port base_o always shows the full 32-bit content of global register 1. A write to number 1 appears on base_o from the next cycle on.
- R4: When n − 128 + b is 128 or more, the access wraps to the bottom of the local bank. For example, number 255 with b = 127 reaches local entry 126.
- R5: Register numbers 64 to 127 always read as zero on both ports. A write to one of these numbers changes no register.
- R6: Both read ports and the write port use the base value held before the current clock edge. An access made in the cycle after a write to number 1 uses the new offset.
- R7: When a read and a write reach the same physical entry in the same cycle, the read returns the old value. There is no forwarding from the write to the read.
- R8: After reset, every global and local register reads as zero and base_o is zero.
- R9: The two read ports work independently. Each returns the entry for its own register number in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears every register |
| rd_a_num | input | 8 | Register number for read port A |
| rd_a_data | output | 32 | Data from read port A (combinational) |
| rd_b_num | input | 8 | Register number for read port B |
| rd_b_data | output | 32 | Data from read port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_num | input | 8 | Register number to write |
| wr_data | input | 32 | Data to write |
| base_o | output | 32 | Current content of global register 1; bits [6:0] are the local offset |

## Verification
The assertions check on every cycle that:
- Reserved numbers read zero.
- A write to the base register shows up on base_o one cycle later.
- A value written to a global number can be read back at once under the same number.
- A value written to a local number can be read back at once under the same number if the offset has not changed.

Some behaviours can only be shown by the bench's scenarios, because they depend on which physical entry a number reaches:
- Wrap-around at the top of the local bank.
- Relocation after a write to the base register.
- Old-value reads when a read and a write collide.
- The fact that writes to reserved numbers disturb nothing.

The bench sweeps every register number at several offsets, including 0, 10, 64 and 127, and compares each read against its own model arrays.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int NUM_W     = 8;
  localparam int DATA_W    = 32;
  localparam int GLOB_N    = 64;
  localparam int LOC_N     = 128;
  localparam int LOC_FIRST = 128;
  localparam int BASE_REG  = 1;
  localparam int GLOB_AW   = $clog2(GLOB_N);
  localparam int LOC_AW    = $clog2(LOC_N);

  typedef enum logic [1:0] {
    KIND_GLOBAL   = 2'd0,
    KIND_RESERVED = 2'd1,
    KIND_LOCAL    = 2'd2
  } num_kind_e;

  // Sort an architectural number into one of the three ranges.
  function automatic num_kind_e classify(input logic [NUM_W-1:0] num);
    if (num < NUM_W'(GLOB_N))           return KIND_GLOBAL;
    else if (num >= NUM_W'(LOC_FIRST))  return KIND_LOCAL;
    else                                return KIND_RESERVED;
  endfunction

  // Physical local entry: offset into the local range plus the base,
  // truncated to the bank's index width so that it wraps.
  function automatic logic [LOC_AW-1:0] relocate(input logic [NUM_W-1:0] num,
                                                 input logic [LOC_AW-1:0] base);
    logic [NUM_W-1:0] off;
    off = num - NUM_W'(LOC_FIRST);
    return off[LOC_AW-1:0] + base;
  endfunction
endpackage

// File: rtl/rrf_addr_map.sv
module rrf_addr_map
  import rrf_pkg::*;
(
  input  logic [NUM_W-1:0]   num,
  input  logic [LOC_AW-1:0]  base,
  output num_kind_e          kind,
  output logic [GLOB_AW-1:0] gidx,
  output logic [LOC_AW-1:0]  lidx
);
  always_comb begin
    kind = classify(num);
    gidx = num[GLOB_AW-1:0];
    lidx = relocate(num, base);
  end
endmodule

// File: rtl/rrf_bank.sv
module rrf_bank #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  parameter int N_RD  = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [W-1:0]          wdata,
  input  logic [N_RD-1:0][AW-1:0] raddr,
  output logic [N_RD-1:0][W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Read ports see the stored value: no forwarding from the write port.
  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/rrf_rotating_regfile.sv
module rrf_rotating_regfile
  import rrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_W-1:0]  rd_a_num,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [NUM_W-1:0]  rd_b_num,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [NUM_W-1:0]  wr_num,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] base_o
);
  localparam int N_PORT = 3;  // 0: read A, 1: read B, 2: write
  localparam int P_WR   = 2;

  logic [N_PORT-1:0][NUM_W-1:0]   port_num;
  num_kind_e                      port_kind [N_PORT];
  logic [N_PORT-1:0][GLOB_AW-1:0] port_gidx;
  logic [N_PORT-1:0][LOC_AW-1:0]  port_lidx;
  logic [LOC_AW-1:0]              base_off;

  assign port_num = {wr_num, rd_b_num, rd_a_num};
  assign base_off = base_o[LOC_AW-1:0];

  for (genvar p = 0; p < N_PORT; p++) begin : g_map
    rrf_addr_map u_map (
      .num  (port_num[p]),
      .base (base_off),
      .kind (port_kind[p]),
      .gidx (port_gidx[p]),
      .lidx (port_lidx[p])
    );
  end

  // Named write events for the banks and the assertions.
  logic glob_we, loc_we;
  assign glob_we = wr_en && (port_kind[P_WR] == KIND_GLOBAL);
  assign loc_we  = wr_en && (port_kind[P_WR] == KIND_LOCAL);

  // Global bank: third read port is tied to the base register.
  logic [2:0][GLOB_AW-1:0] g_raddr;
  logic [2:0][DATA_W-1:0]  g_rdata;
  assign g_raddr = {GLOB_AW'(BASE_REG), port_gidx[1], port_gidx[0]};

  rrf_bank #(.DEPTH(GLOB_N), .W(DATA_W), .N_RD(3)) u_glob (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (glob_we),
    .waddr (port_gidx[P_WR]),
    .wdata (wr_data),
    .raddr (g_raddr),
    .rdata (g_rdata)
  );

  logic [1:0][LOC_AW-1:0] l_raddr;
  logic [1:0][DATA_W-1:0] l_rdata;
  assign l_raddr = {port_lidx[1], port_lidx[0]};

  rrf_bank #(.DEPTH(LOC_N), .W(DATA_W), .N_RD(2)) u_loc (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (loc_we),
    .waddr (port_lidx[P_WR]),
    .wdata (wr_data),
    .raddr (l_raddr),
    .rdata (l_rdata)
  );

  assign base_o = g_rdata[2];

  function automatic logic [DATA_W-1:0] pick(input num_kind_e k,
                                             input logic [DATA_W-1:0] g,
                                             input logic [DATA_W-1:0] l);
    case (k)
      KIND_GLOBAL: return g;
      KIND_LOCAL:  return l;
      default:     return '0;
    endcase
  endfunction

  assign rd_a_data = pick(port_kind[0], g_rdata[0], l_rdata[0]);
  assign rd_b_data = pick(port_kind[1], g_rdata[1], l_rdata[1]);

  // ---------------- assertions ----------------
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R5: reserved numbers read zero on both ports
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_num >= NUM_W'(GLOB_N) && rd_a_num < NUM_W'(LOC_FIRST)) |-> rd_a_data == '0);
  a_r5_reserved_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_num >= NUM_W'(GLOB_N) && rd_b_num < NUM_W'(LOC_FIRST)) |-> rd_b_data == '0);

  // R3 / R6: base write is visible on base_o from the next cycle on
  a_r3_base_update: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en && wr_num == NUM_W'(BASE_REG))) |-> base_o == $past(wr_data));

  // R1: global write reads back under the same number
  a_r1_global_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en && wr_num < NUM_W'(GLOB_N)) && rd_a_num == $past(wr_num))
    |-> rd_a_data == $past(wr_data));

  // R2: local write reads back under the same number while the base is unchanged
  a_r2_local_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en && wr_num >= NUM_W'(LOC_FIRST)) && rd_b_num == $past(wr_num)
     && base_o == $past(base_o)) |-> rd_b_data == $past(wr_data));
endmodule

// File: tb/rrf_rotating_regfile_test.sv
`timescale 1ns/1ps
module rrf_rotating_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rd_a_num = '0, rd_b_num = '0, wr_num = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, base_o;
  logic        wr_en = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rrf_rotating_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_num(rd_a_num), .rd_a_data(rd_a_data),
    .rd_b_num(rd_b_num), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .base_o(base_o)
  );

  logic [31:0] gm [64];
  logic [31:0] lm [128];
  int vectors = 0;
  int errors  = 0;
  bit base_just_written = 0;

  function automatic int cur_base();
    return int'(gm[1] % 128);
  endfunction

  // Expected read value computed from the model arrays.
  function automatic logic [31:0] expect_rd(input int n);
    if (n < 64)        return gm[n];
    else if (n < 128)  return 32'd0;
    else               return lm[(n + cur_base()) % 128];
  endfunction

  function automatic string tag_of(input int n, input bit coll);
    if (coll)                      return "R7";
    if (base_just_written && n >= 128) return "R6";
    if (n < 64)                    return "R1";
    if (n < 128)                   return "R5";
    if (n - 128 + cur_base() >= 128) return "R4";
    return "R2";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // One cycle: drive at negedge, check reads before the edge, update model.
  task automatic step(input bit we, input int wn, input logic [31:0] wd,
                      input int an, input int bn);
    bit coll_a, coll_b;
    @(negedge clk);
    wr_en = we; wr_num = 8'(wn); wr_data = wd;
    rd_a_num = 8'(an); rd_b_num = 8'(bn);
    #2;
    coll_a = we && an == wn && wn != 1 && !(wn >= 64 && wn < 128);
    coll_b = we && bn == wn && wn != 1 && !(wn >= 64 && wn < 128);
    check(tag_of(an, coll_a), "port A", rd_a_data, expect_rd(an));
    check(coll_b ? "R7" : "R9", "port B", rd_b_data, expect_rd(bn));
    check("R3", "base_o", base_o, gm[1]);
    @(posedge clk);
    base_just_written = 0;
    if (we) begin
      if (wn < 64) begin
        gm[wn] = wd;
        if (wn == 1) base_just_written = 1;
      end else if (wn >= 128) begin
        lm[(wn + cur_base()) % 128] = wd;
      end
    end
  endtask

  task automatic read_all();
    for (int n = 0; n < 256; n++) step(1'b0, 0, 32'd0, n, 255 - n);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) gm[i] = '0;
    for (int i = 0; i < 128; i++) lm[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    check("R8", "base_o in reset", base_o, 32'd0);
    check("R8", "port A in reset", rd_a_data, 32'd0);
    rst_n = 1'b1;
    for (int n = 0; n < 256; n++) begin
      step(1'b0, 0, 32'd0, n, n);
    end
    // R1: fill globals (base stays 0 for now)
    for (int n = 0; n < 64; n++)
      if (n != 1) step(1'b1, n, 32'h6000_0000 + 32'(n * 7), n, 255 - n);
    // R5: writes to reserved numbers change nothing
    for (int n = 64; n < 128; n++) step(1'b1, n, 32'hDEAD_0000 + 32'(n), n, 128);
    // Sweep of offsets, including wrap-around values
    foreach (bases_list[k]) begin
      int b;
      b = bases_list[k];
      step(1'b1, 1, 32'hABC0_0000 | 32'(b), 130, 1);
      // R6: first access after the base write uses the new offset
      step(1'b0, 0, 32'd0, 128, 255);
      for (int n = 128; n < 256; n++)
        step(1'b1, n, {8'(b), 8'(n), 16'h5A3C}, n, (n < 255) ? n + 1 : 128);
      read_all();
    end
    // R2 frame overlap: moving the base by 3 makes number 131 alias number 128
    step(1'b1, 1, 32'd20, 0, 0);
    step(1'b1, 131, 32'hF00D_0003, 131, 128);
    step(1'b1, 1, 32'd23, 128, 131);
    step(1'b0, 0, 32'd0, 128, 131);
    check("R2", "alias after frame move", rd_a_data, 32'hF00D_0003);
    // R4: number 255 with base 127 reaches local entry 126
    step(1'b1, 1, 32'd127, 0, 0);
    step(1'b1, 255, 32'h0000_0126, 255, 0);
    step(1'b1, 1, 32'd0, 0, 0);
    step(1'b0, 0, 32'd0, 254, 128);
    check("R4", "wrapped entry 126", rd_a_data, 32'h0000_0126);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  int bases_list [5] = '{0, 10, 127, 64, 1};
endmodule